// File: doc/BRIEF.md
# 16x I/Q Interpolation Chain

This block raises the sample rate of a pair of baseband streams, in-phase (I) and quadrature (Q), by a fixed factor of sixteen. It is meant to sit ahead of a quadrature modulator. Both channels run through identical filters and stay in lockstep. The first stage multiplies the rate by four with two cascaded 2x half-band interpolators that have fixed taps. These remove the spectral images that zero-stuffing leaves between the old and new sample rates. The second stage multiplies the rate by four again with a third-order cascaded integrator-comb (CIC) interpolator. Its combs run at the intermediate rate and its integrators run at the output rate. The CIC output is shifted down to cancel the CIC gain, so the chain has unity DC gain. It is then clamped to the output word width.

Everything runs on one clock at the output rate. A free-running 16-phase sequencer raises `in_ready_o` for one cycle in every sixteen, and the source must present a sample pair in that slot. If `in_valid_i` is low in that slot, a zero pair is fed in instead. After a fixed warm-up, the block delivers one I/Q pair on every clock.

Top module: `iq_interp16`

## Requirements
- R1: While `rst_ni` is low, `in_ready_o` and `out_valid_o` are 0 and both outputs read 0.
- R2: `in_ready_o` is high in the first cycle after reset is released and then exactly once every 16 cycles.
- R3: A ready slot with `in_valid_i` low injects a zero pair, so with no valid input for at least 8 slots both outputs read exactly 0.
- R4: A constant input X held on a channel settles to exactly X on that channel's output (unity DC gain, no rounding bias).
- R5: The I and Q channels are independent: different constants on each settle to their own values.
- R6: When the I and Q inputs are equal at every accepted slot, `out_i_o` equals `out_q_o` on every cycle.
- R7: Outputs are clamped to the signed `DW`-bit range. Filter overshoot on a full-scale step never wraps to the opposite sign.
- R8: `out_valid_o` is 0 for the first `LAT` clock edges after reset and 1 from then on, with a new output pair on every clock.
- R9: Each 2x half-band stage passes every other output sample through unchanged. It forms the samples in between from four neighbours with weights -1/16, 9/16, 9/16, -1/16, and each stage adds one bit of headroom.
- R10: The CIC stage has 3 sections with rate 4 and grows internally by 6 bits. Its result is shifted right arithmetically by 4 bits (floor) before clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pair present in the ready slot |
| in_ready_o | output | 1 | Input slot strobe, one cycle in 16 |
| in_i_i | input | DW | In-phase input sample, signed |
| in_q_i | input | DW | Quadrature input sample, signed |
| out_valid_o | output | 1 | Output stream is running |
| out_i_o | output | DW | In-phase output sample, signed |
| out_q_o | output | DW | Quadrature output sample, signed |

## Verification
Four properties are checked on every cycle: the sixteen-cycle spacing of the ready slot, the exact warm-up count before `out_valid_o` rises, equal outputs whenever every accepted pair so far had equal halves, and zero outputs after a run of empty slots. Only the bench scenarios can show the arithmetic itself. These scenarios cover exact unity gain for positive, negative and full-scale constants on separate channels, a step between the rails that would expose wrap-around in the clamp, and reset taken in the middle of a run.

// File: rtl/iq_interp_pkg.sv
package iq_interp_pkg;
  localparam int unsigned RATE_LOG  = 4;   // 16x overall
  localparam int unsigned HB_SHIFT  = 4;   // half-band weights are n/16
  localparam int unsigned HB_STAGES = 2;
  localparam int unsigned CIC_N     = 3;
  localparam int unsigned CIC_R_LOG = 2;
  localparam int unsigned CIC_GROW  = CIC_N * CIC_R_LOG;
  localparam int unsigned CIC_NORM  = (CIC_N - 1) * CIC_R_LOG;
endpackage

// File: rtl/iq_phase_ctl.sv
module iq_phase_ctl
  import iq_interp_pkg::*;
#(
  parameter int unsigned LAT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic take_o,
  output logic hb1_load_o,
  output logic hb1_odd_o,
  output logic hb2_shift_o,
  output logic hb2_load_o,
  output logic hb2_odd_o,
  output logic comb_o,
  output logic inj_o,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [RATE_LOG-1:0] ph_q;
  logic [CW-1:0]       cnt_q;

  // ph resets to all ones so the first slot opens one edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '1;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (cnt_q != CW'(LAT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // schedule: shift(0) hb1 out(1,9) hb2 shift(2,10) hb2 out(3,7,11,15)
  // comb(0,4,8,12) inject(1,5,9,13)
  assign take_o      = (ph_q == '0);
  assign hb1_load_o  = (ph_q[2:0] == 3'd1);
  assign hb1_odd_o   = ph_q[3];
  assign hb2_shift_o = (ph_q[2:0] == 3'd2);
  assign hb2_load_o  = (ph_q[1:0] == 2'd3);
  assign hb2_odd_o   = ph_q[2];
  assign comb_o      = (ph_q[1:0] == 2'd0);
  assign inj_o       = (ph_q[1:0] == 2'd1);
  assign valid_o     = (cnt_q == CW'(LAT));
endmodule

// File: rtl/iq_hb2x.sv
module iq_hb2x
  import iq_interp_pkg::*;
#(
  parameter int unsigned IW = 12,
  parameter int unsigned OW = IW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [IW-1:0] x_i,
  input  logic                 load_i,
  input  logic                 odd_i,
  output logic signed [OW-1:0] y_o
);
  localparam int unsigned TAPS = 4;
  localparam int unsigned AW   = IW + 6;

  logic signed [IW-1:0] h_q [TAPS];
  logic signed [AW-1:0] inner_w, outer_w, acc_w, mid_w, even_w;
  logic signed [OW-1:0] y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) h_q[0] <= '0;
    else if (shift_i) h_q[0] <= x_i;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) h_q[k] <= '0;
      else if (shift_i) h_q[k] <= h_q[k-1];
    end
  end

  // odd phase: (-h0 + 9 h1 + 9 h2 - h3) / 16, even phase: h2 passed through
  assign inner_w = AW'(h_q[1]) + AW'(h_q[2]);
  assign outer_w = AW'(h_q[0]) + AW'(h_q[3]);
  assign acc_w   = (inner_w <<< 3) + inner_w - outer_w;
  assign mid_w   = acc_w >>> HB_SHIFT;
  assign even_w  = AW'(h_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else if (load_i) y_q <= odd_i ? OW'(mid_w) : OW'(even_w);
  end

  assign y_o = y_q;
endmodule

// File: rtl/iq_cic_interp.sv
module iq_cic_interp
  import iq_interp_pkg::*;
#(
  parameter int unsigned IW = 14,
  parameter int unsigned OW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 comb_i,
  input  logic                 inj_i,
  input  logic signed [IW-1:0] x_i,
  output logic signed [OW-1:0] y_o
);
  localparam int unsigned CW = IW + CIC_GROW;
  localparam logic signed [CW-1:0] SAT_HI = CW'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [CW-1:0] SAT_LO = -CW'(64'sd1 <<< (OW - 1));

  logic signed [CW-1:0] c_w  [CIC_N+1];
  logic signed [CW-1:0] d_q  [CIC_N];
  logic signed [CW-1:0] ig_q [CIC_N];
  logic signed [CW-1:0] cr_q, u_w, sh_w;
  logic signed [OW-1:0] y_q;

  assign c_w[0] = CW'(x_i);

  for (genvar k = 0; k < CIC_N; k++) begin : g_comb
    assign c_w[k+1] = c_w[k] - d_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) d_q[k] <= '0;
      else if (comb_i) d_q[k] <= c_w[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cr_q <= '0;
    else if (comb_i) cr_q <= c_w[CIC_N];
  end

  // zero-stuffing into the high-rate integrators
  assign u_w = inj_i ? cr_q : '0;

  for (genvar k = 0; k < CIC_N; k++) begin : g_integ
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ig_q[k] <= '0;
        else ig_q[k] <= ig_q[k] + u_w;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ig_q[k] <= '0;
        else ig_q[k] <= ig_q[k] + ig_q[k-1];
      end
    end
  end

  assign sh_w = ig_q[CIC_N-1] >>> CIC_NORM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else if (sh_w > SAT_HI) y_q <= OW'(SAT_HI);
    else if (sh_w < SAT_LO) y_q <= OW'(SAT_LO);
    else y_q <= OW'(sh_w);
  end

  assign y_o = y_q;
endmodule

// File: rtl/iq_interp16.sv
module iq_interp16
  import iq_interp_pkg::*;
#(
  parameter int unsigned DW  = 12,
  parameter int unsigned LAT = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_i_i,
  input  logic [DW-1:0] in_q_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_i_o,
  output logic [DW-1:0] out_q_o
);
  localparam int unsigned NCH = 2;
  localparam int unsigned W1  = DW + 1;
  localparam int unsigned W2  = DW + HB_STAGES;

  logic take, hb1_load, hb1_odd, hb2_shift, hb2_load, hb2_odd, comb, inj;
  logic signed [DW-1:0] din  [NCH];
  logic signed [DW-1:0] dout [NCH];

  iq_phase_ctl #(.LAT(LAT)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_o      (take),
    .hb1_load_o  (hb1_load),
    .hb1_odd_o   (hb1_odd),
    .hb2_shift_o (hb2_shift),
    .hb2_load_o  (hb2_load),
    .hb2_odd_o   (hb2_odd),
    .comb_o      (comb),
    .inj_o       (inj),
    .valid_o     (out_valid_o)
  );

  // empty slot feeds zero
  assign din[0] = in_valid_i ? $signed(in_i_i) : '0;
  assign din[1] = in_valid_i ? $signed(in_q_i) : '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [W1-1:0] y1;
    logic signed [W2-1:0] y2;

    iq_hb2x #(.IW(DW), .OW(W1)) i_hb1 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (take),
      .x_i     (din[ch]),
      .load_i  (hb1_load),
      .odd_i   (hb1_odd),
      .y_o     (y1)
    );

    iq_hb2x #(.IW(W1), .OW(W2)) i_hb2 (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (hb2_shift),
      .x_i     (y1),
      .load_i  (hb2_load),
      .odd_i   (hb2_odd),
      .y_o     (y2)
    );

    iq_cic_interp #(.IW(W2), .OW(DW)) i_cic (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .comb_i (comb),
      .inj_i  (inj),
      .x_i    (y2),
      .y_o    (dout[ch])
    );
  end

  assign in_ready_o = take;
  assign out_i_o    = dout[0];
  assign out_q_o    = dout[1];
endmodule

// File: rtl/iq_interp16_chk.sv
module iq_interp16_chk #(
  parameter int unsigned DW  = 12,
  parameter int unsigned LAT = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [DW-1:0] in_i_i,
  input logic [DW-1:0] in_q_i,
  input logic          out_valid_o,
  input logic [DW-1:0] out_i_o,
  input logic [DW-1:0] out_q_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] cyc_q;
  logic [3:0]    gap_q;
  logic [3:0]    idle_q;
  logic          seen_q, eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      gap_q  <= '0;
      idle_q <= '0;
      seen_q <= 1'b0;
      eq_q   <= 1'b1;
    end else begin
      if (cyc_q != CW'(LAT)) cyc_q <= cyc_q + 1'b1;
      gap_q <= in_ready_o ? 4'd0 : gap_q + 4'd1;
      if (in_ready_o) seen_q <= 1'b1;
      if (in_ready_o && in_valid_i && in_i_i != in_q_i) eq_q <= 1'b0;
      if (in_ready_o && in_valid_i) idle_q <= '0;
      else if (in_ready_o && idle_q != 4'd8) idle_q <= idle_q + 4'd1;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni)
      a_reset_r1: assert (!in_ready_o && !out_valid_o && out_i_o == '0 && out_q_o == '0);
  end

  p_ready_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (in_ready_o == (gap_q == 4'd15)));

  p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (cyc_q == CW'(LAT)));

  p_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_q |-> (out_i_o == out_q_o));

  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == 4'd8) |-> (out_i_o == '0 && out_q_o == '0));
endmodule

bind iq_interp16 iq_interp16_chk #(.DW(DW), .LAT(LAT)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_i_i      (in_i_i),
  .in_q_i      (in_q_i),
  .out_valid_o (out_valid_o),
  .out_i_o     (out_i_o),
  .out_q_o     (out_q_o)
);

// File: tb/test_iq_interp16.sv
`timescale 1ns/1ps
module test_iq_interp16;
  localparam int DW  = 12;
  localparam int LAT = 32;
  localparam int NV  = 6;
  localparam logic signed [DW-1:0] VI [NV] = '{12'sd0, 12'sd1000, 12'sd2047, -12'sd1, -12'sd2048, 12'sd5};
  localparam logic signed [DW-1:0] VQ [NV] = '{12'sd0, -12'sd1000, -12'sd2048, 12'sd1, 12'sd2047, -12'sd5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_i = '0, in_q = '0, out_i, out_q;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iq_interp16 #(.DW(DW), .LAT(LAT)) i_iq_interp16 (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .in_ready_o (in_ready),
    .in_i_i (in_i), .in_q_i (in_q), .out_valid_o (out_valid), .out_i_o (out_i), .out_q_o (out_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    int ready_cnt;
    bit crossed;
    int rev;
    // R1 reset state
    wait_cyc(4);
    chk(!in_ready && !out_valid && out_i == 0 && out_q == 0, "R1 reset", int'(out_i), 0);
    rst_n = 1'b1;
    // R8 warm-up count, R2 slot timing (sample after k edges)
    bad = 0; ready_cnt = 0;
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (out_valid != (k >= LAT)) bad++;
      if (in_ready != ((k - 1) % 16 == 0)) bad++;
      if (in_ready) ready_cnt++;
    end
    chk(bad == 0, "R8 R2 warm-up and slot timing", bad, 0);
    chk(ready_cnt == 4, "R2 slot count", ready_cnt, 4);

    // table walk: R4 R5 R9 R10 unity gain per channel
    in_valid = 1'b1;
    for (int v = 0; v < NV; v++) begin
      in_i = VI[v]; in_q = VQ[v];
      wait_cyc(40 * 16);
      bad = 0;
      for (int k = 0; k < 16; k++) begin
        if (out_i != VI[v] || out_q != VQ[v] || !out_valid) bad++;
        @(negedge clk);
      end
      chk(bad == 0 && out_i == VI[v], "R4 R9 R10 I steady", int'(out_i), int'(VI[v]));
      chk(bad == 0 && out_q == VQ[v], "R5 R8 Q steady", int'(out_q), int'(VQ[v]));
    end

    // R3 empty slots inject zero
    in_i = 12'sd1500; in_q = -12'sd700;
    wait_cyc(40 * 16);
    in_valid = 1'b0;
    wait_cyc(20 * 16);
    chk(out_i == 0 && out_q == 0, "R3 idle zero", int'(out_i) + int'(out_q), 0);

    // R6 equal inputs keep outputs aligned every cycle
    in_valid = 1'b1;
    bad = 0;
    for (int k = 0; k < 800; k++) begin
      in_i = DW'((k * 523) % 4096);
      in_q = in_i;
      @(negedge clk);
      if (out_i != out_q) bad++;
    end
    chk(bad == 0, "R6 alignment", bad, 0);

    // R7 rail-to-rail step must not wrap
    in_i = -12'sd2048; in_q = -12'sd2048;
    wait_cyc(40 * 16);
    in_i = 12'sd2047; in_q = 12'sd2047;
    crossed = 1'b0; rev = 0;
    for (int k = 0; k < 40 * 16; k++) begin
      @(negedge clk);
      if (out_i > 12'sd1023) crossed = 1'b1;
      if (crossed && out_i < 0) rev++;
    end
    chk(rev == 0, "R7 no wrap on overshoot", rev, 0);
    chk(out_i == 12'sd2047 && out_q == 12'sd2047, "R7 settle at rail", int'(out_i), 2047);

    // R1 reset mid-run
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(!in_ready && !out_valid && out_i == 0 && out_q == 0, "R1 mid-run reset", int'(out_i), 0);
    rst_n = 1'b1;
    wait_cyc(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule